// File: doc/BRIEF.md
# Thyristor Bridge Gating Sequencer

This block produces the gate word for a single-phase full bridge built from forced-commutated thyristors. It uses one pulse per half cycle. The word has eight bits: four main thyristors, plus four auxiliary thyristors that fire the commutation circuit of their main device.

A free-running period timer starts each half cycle. At the start of a half cycle the block applies full supply voltage across the load, alternating the polarity from one half cycle to the next. A second one-shot timer sets how long the full voltage is held. What happens after that interval depends on the modulation style:
- In zero-voltage style the bridge freewheels through two devices on the same rail.
- In zero-current style every main device is turned off, so the load current is forced to zero.

A dual setting runs zero-voltage modulation in steady state. It switches to zero-current modulation when the over-current or over-voltage limit pulse fires. Every gate change is looked up in a small pattern table from the sequencer phase and the polarity.

Top module: `thy_gate_seq`

## Requirements
- R1: While reset is held, and until the first period-timer expiry, `gate_o` is all zero.
- R2: The period timer expires at the first clock edge after reset is released. It then expires every `period_i`+1 clocks, and each expiry starts a new half cycle in the full-voltage phase.
- R3: The first half cycle is positive and the polarity alternates on every expiry.
  - Positive full voltage gates bits 0 and 3 (main word 4'b1001).
  - Negative full voltage gates bits 1 and 2 (main word 4'b0110).
- R4: In zero-voltage style, full voltage is held for (effective on value + 1) clocks. The zero pattern follows for the rest of the half cycle: bits 0 and 2 (4'b0101) when positive, bits 1 and 3 (4'b1010) when negative.
- R5: An `on_time_i` greater than or equal to `period_i` is treated as `period_i`-1.
- R6: In zero-current style, all four main bits go low once the full-voltage interval ends, and they stay low until the next expiry.
- R7: Whenever main bit i falls, auxiliary bit i+4 goes high on the same clock edge and stays high for `COMM_CYC` clocks.
- R8: Dual mode, limit during full voltage. If `ilim_i` or `vlim_i` is sampled high during the full-voltage interval of a zero-voltage half cycle, all main bits go low at that edge. They stay low for the rest of the half cycle.
- R9: Dual mode, limit at other times. If a limit is sampled high during the zero or off interval, or on the expiry edge itself, the next half cycle (or the one starting at that edge) runs zero-current modulation. Later half cycles return to zero-voltage modulation.
- R10: With `mode_i` = 2'b00 (zero-voltage only) or 2'b01 (zero-current only), the limit inputs have no effect. `mode_i` = 2'b10 or 2'b11 selects dual mode.
- R11: Bits 0 and 1 are never both high, and bits 2 and 3 are never both high. These are the two bridge legs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Period timer reload value (≥ 1) |
| on_time_i | input | CNT_W | Full-voltage interval value |
| mode_i | input | 2 | 00 zero-voltage, 01 zero-current, 1x dual |
| ilim_i | input | 1 | Load current limit pulse |
| vlim_i | input | 1 | Load voltage limit pulse |
| gate_o | output | 8 | Gate word: [3:0] main, [7:4] auxiliary |

## Verification
The bench builds the block with `CNT_W` = 8 and `COMM_CYC` = 3, and runs a period value of 9, so each half cycle lasts ten clocks. This makes it possible to check several whole half cycles edge by edge, including the overlap of two commutation pulses when the clamped on value leaves a single-clock zero interval. It also reaches limit pulses placed in the full interval, in the zero interval and on the expiry edge itself.

// File: rtl/thy_gate_pkg.sv
package thy_gate_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FULL = 2'd1,
    PH_ZERO = 2'd2,
    PH_OFF  = 2'd3
  } phase_e;

  localparam logic [1:0] MODE_ZV = 2'b00;
  localparam logic [1:0] MODE_ZC = 2'b01;

  // main gate table, bit0..3 = T1..T4, pos = positive half cycle
  function automatic logic [3:0] main_pattern(phase_e ph, logic pos);
    logic [3:0] pat;
    unique case (ph)
      PH_FULL: pat = pos ? 4'b1001 : 4'b0110;
      PH_ZERO: pat = pos ? 4'b0101 : 4'b1010;
      default: pat = 4'b0000;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/period_timer.sv
module period_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (expire_o) cnt_q <= reload_i;
    else               cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/on_timer.sv
module on_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] on_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] on_eff;
  logic             act_q;

  // keep at least one clock of off interval per half cycle
  assign on_eff   = (on_i >= period_i) ? (period_i - 1'b1) : on_i;
  assign expire_o = act_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= on_eff;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/phase_ctrl.sv
module phase_ctrl
  import thy_gate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       per_ev_i,
  input  logic       on_ev_i,
  input  logic [1:0] mode_i,
  input  logic       lim_i,
  output phase_e     phase_q_o,
  output logic       pos_q_o,
  output phase_e     phase_n_o,
  output logic       pos_n_o
);

  phase_e phase_q, phase_n;
  logic   pos_q, pos_n;
  logic   zc_q, zc_n;
  logic   pend_q, pend_n;
  logic   is_dual, is_zc;

  assign is_dual = mode_i[1];
  assign is_zc   = (mode_i == MODE_ZC);

  always_comb begin
    phase_n = phase_q;
    pos_n   = pos_q;
    zc_n    = zc_q;
    pend_n  = pend_q;
    if (per_ev_i) begin
      phase_n = PH_FULL;
      pos_n   = ~pos_q;
      zc_n    = is_zc | (is_dual & (pend_q | lim_i));
      pend_n  = 1'b0;
    end else begin
      unique case (phase_q)
        PH_FULL: begin
          if (is_dual && lim_i && !zc_q) begin
            phase_n = PH_OFF;   // overload: cut full voltage now
            zc_n    = 1'b1;
          end else if (on_ev_i) begin
            phase_n = zc_q ? PH_OFF : PH_ZERO;
          end
        end
        PH_ZERO, PH_OFF: begin
          if (is_dual && lim_i) pend_n = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      pos_q   <= 1'b0;
      zc_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      pos_q   <= pos_n;
      zc_q    <= zc_n;
      pend_q  <= pend_n;
    end
  end

  assign phase_q_o = phase_q;
  assign pos_q_o   = pos_q;
  assign phase_n_o = phase_n;
  assign pos_n_o   = pos_n;

endmodule

// File: rtl/comm_pulse.sv
module comm_pulse #(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned PW_CYC = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] main_cur_i,
  input  logic [N_CH-1:0] main_nxt_i,
  output logic [N_CH-1:0] aux_o
);

  localparam int unsigned PW_W = $clog2(PW_CYC + 1);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [PW_W-1:0] cnt_q;
    logic            fall;

    assign fall     = main_cur_i[i] & ~main_nxt_i[i];
    assign aux_o[i] = (cnt_q != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (fall)         cnt_q <= PW_W'(PW_CYC);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/thy_gate_seq.sv
module thy_gate_seq
  import thy_gate_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned COMM_CYC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] on_time_i,
  input  logic [1:0]       mode_i,
  input  logic             ilim_i,
  input  logic             vlim_i,
  output logic [7:0]       gate_o
);

  localparam int unsigned N_MAIN = 4;

  logic              per_ev, on_ev;
  phase_e            phase_q, phase_n;
  logic              pos_q, pos_n;
  logic [N_MAIN-1:0] main_cur, main_nxt, aux;

  period_timer #(.CNT_W(CNT_W)) u_per (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (period_i),
    .expire_o (per_ev)
  );

  on_timer #(.CNT_W(CNT_W)) u_on (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (per_ev),
    .period_i (period_i),
    .on_i     (on_time_i),
    .expire_o (on_ev)
  );

  phase_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .per_ev_i  (per_ev),
    .on_ev_i   (on_ev),
    .mode_i    (mode_i),
    .lim_i     (ilim_i | vlim_i),
    .phase_q_o (phase_q),
    .pos_q_o   (pos_q),
    .phase_n_o (phase_n),
    .pos_n_o   (pos_n)
  );

  assign main_cur = main_pattern(phase_q, pos_q);
  assign main_nxt = main_pattern(phase_n, pos_n);

  comm_pulse #(.N_CH(N_MAIN), .PW_CYC(COMM_CYC)) u_comm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .main_cur_i (main_cur),
    .main_nxt_i (main_nxt),
    .aux_o      (aux)
  );

  assign gate_o = {aux, main_cur};

endmodule

// File: rtl/thy_gate_seq_chk.sv
module thy_gate_seq_chk
  import thy_gate_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] gate_i,
  input phase_e     phase_i,
  input logic       per_ev_i
);

  p_leg_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_i[0] && gate_i[1]) && !(gate_i[2] && gate_i[3]));

  // R3: mains are either all off or exactly one diagonal/rail pair
  p_main_pairs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(gate_i[3:0]) == 0) || ($countones(gate_i[3:0]) == 2));

  p_idle_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_IDLE) |-> (gate_i == 8'h00));

  p_expiry_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_ev_i |=> (phase_i == PH_FULL));

  for (genvar i = 0; i < 4; i++) begin : g_aux
    p_aux_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(gate_i[i]) && !gate_i[i]) |-> gate_i[i+4]);
  end

endmodule

bind thy_gate_seq thy_gate_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .gate_i   (gate_o),
  .phase_i  (phase_q),
  .per_ev_i (per_ev)
);

// File: tb/thy_gate_seq_tb_top.sv
`timescale 1ns/1ps
module thy_gate_seq_tb_top;

  localparam int unsigned CNT_W = 8;
  localparam int unsigned COMM  = 3;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] period_i = '0;
  logic [CNT_W-1:0] on_time_i = '0;
  logic [1:0]       mode_i = 2'b00;
  logic             ilim_i = 1'b0;
  logic             vlim_i = 1'b0;
  logic [7:0]       gate_o;

  int total = 0;
  int bad   = 0;
  int k     = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  thy_gate_seq #(.CNT_W(CNT_W), .COMM_CYC(COMM)) dut_i (
    .clk_i, .rst_ni, .period_i, .on_time_i, .mode_i, .ilim_i, .vlim_i, .gate_o
  );

  task automatic tick();
    @(posedge clk_i);
    #2;
    k++;
  endtask

  task automatic go_to(input int n);
    while (k < n) tick();
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    total++;
    if (gate_o !== exp) begin
      bad++;
      $display("FAIL %s k=%0d gate actual=%h expected=%h", req, k, gate_o, exp);
    end
  endtask

  // after return, k=0 is the state following the first expiry edge
  task automatic do_reset(input logic [1:0] md, input int per, input int on);
    rst_ni    = 1'b0;
    mode_i    = md;
    period_i  = CNT_W'(per);
    on_time_i = CNT_W'(on);
    ilim_i    = 1'b0;
    vlim_i    = 1'b0;
    tick();
    tick();
    chk("R1 reset", 8'h00);
    rst_ni = 1'b1;
    k = -1;
    tick();
  endtask

  task automatic t_zv();
    do_reset(2'b00, 9, 4);
    chk("R3 first half positive", 8'h09);
    go_to(4);  chk("R4 full held", 8'h09);
    go_to(5);  chk("R4/R7 zero pos + aux T4", 8'h85);
    go_to(7);  chk("R7 aux last cycle", 8'h85);
    go_to(8);  chk("R7 aux ended", 8'h05);
    go_to(9);  chk("R2 still zero before expiry", 8'h05);
    go_to(10); chk("R2/R3 negative full + aux T1", 8'h16);
    go_to(15); chk("R4 zero neg + aux T3", 8'h4A);
    go_to(18); chk("R4 zero neg", 8'h0A);
    go_to(20); chk("R3 back to positive + aux T2", 8'h29);
  endtask

  task automatic t_clamp();
    do_reset(2'b00, 9, 20);
    go_to(8);  chk("R5 clamp full", 8'h09);
    go_to(9);  chk("R5 clamp one zero clock", 8'h85);
    go_to(10); chk("R5/R7 overlapping aux", 8'h96);
    do_reset(2'b00, 9, 9);
    go_to(8);  chk("R5 equal value full", 8'h09);
    go_to(9);  chk("R5 equal value zero", 8'h85);
  endtask

  task automatic t_zc();
    do_reset(2'b01, 9, 4);
    go_to(4);  chk("R6 full", 8'h09);
    go_to(5);  chk("R6/R7 off + aux T1 T4", 8'h90);
    go_to(8);  chk("R6 off", 8'h00);
    go_to(10); chk("R6 negative full", 8'h06);
    go_to(15); chk("R6/R7 off + aux T2 T3", 8'h60);
    go_to(19); chk("R6 off held", 8'h00);
  endtask

  task automatic t_lim_full();
    do_reset(2'b10, 9, 4);
    go_to(2); chk("R8 before limit", 8'h09);
    ilim_i = 1'b1;
    tick();
    ilim_i = 1'b0;
    chk("R8 cut at limit", 8'h90);
    go_to(6);  chk("R8 off", 8'h00);
    go_to(9);  chk("R8 off rest of half", 8'h00);
    go_to(10); chk("R8 next half full", 8'h06);
    go_to(15); chk("R8 next half zero-voltage", 8'h4A);
  endtask

  task automatic t_lim_zero();
    do_reset(2'b11, 9, 4);
    go_to(6);
    vlim_i = 1'b1;
    tick();
    vlim_i = 1'b0;
    chk("R9 zero kept in current half", 8'h85);
    go_to(9);  chk("R9 zero kept", 8'h05);
    go_to(10); chk("R9 next half full", 8'h16);
    go_to(15); chk("R9 next half zero-current", 8'h60);
    go_to(20); chk("R9 following half full", 8'h09);
    go_to(25); chk("R9 back to zero-voltage", 8'h85);
  endtask

  task automatic t_lim_edge();
    do_reset(2'b10, 9, 4);
    go_to(9);
    ilim_i = 1'b1;
    tick();
    ilim_i = 1'b0;
    chk("R9 expiry edge limit full", 8'h16);
    go_to(15); chk("R9 expiry edge limit zc", 8'h60);
    go_to(25); chk("R9 then zero-voltage", 8'h85);
  endtask

  task automatic t_ignore();
    do_reset(2'b00, 9, 4);
    go_to(2);
    ilim_i = 1'b1;
    vlim_i = 1'b1;
    tick();
    ilim_i = 1'b0;
    vlim_i = 1'b0;
    chk("R10 zv mode ignores limit", 8'h09);
    go_to(5);  chk("R10 zv zero unchanged", 8'h85);
    go_to(15); chk("R10 no zc in next half", 8'h4A);
    do_reset(2'b01, 9, 4);
    go_to(6);
    ilim_i = 1'b1;
    tick();
    ilim_i = 1'b0;
    go_to(10); chk("R10 zc mode ignores limit", 8'h06);
    go_to(14); chk("R10 zc full length kept", 8'h06);
  endtask

  initial begin
    t_zv();
    t_clamp();
    t_zc();
    t_lim_full();
    t_lim_zero();
    t_lim_edge();
    t_ignore();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog k=%0d actual=hung expected=finished", k);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule